// File: doc/BRIEF.md
# Byte-Lane Data Memory

This block is a data memory that the load/store unit of a simple core reaches with byte addresses. Each access presents a 32-bit address, 32-bit write data, an enable and a 2-bit operation code. The code picks one of four operations: a full-word read, a single-byte store, a halfword store or a full-word store. Storage is organised as words, and each word is split into four byte lanes. A store writes only the lanes it covers, so a narrow store leaves the rest of the word as it was.

Natural alignment is enforced. A halfword access must sit on an even address, and a word access must sit on an address that is a multiple of four. An access that breaks this rule raises an error flag in the same cycle and does not touch storage. Lanes are numbered big-endian, and the word index comes from the address bits just above the byte offset. The depth is a parameter, and address bits above the index are ignored, so higher addresses alias onto lower ones.

Top module: `lane_mem`

## Requirements
- R1: While reset is low, every stored word is cleared to zero, so a read after reset returns 0.
- R2: With the enable high, op code 00 and address bits [1:0] equal to 00, the read output shows the stored word at index addr[IDX_W+1:2], and storage does not change.
- R3: Op code 01 writes din[7:0] into one lane, chosen by address bits [1:0]: offset 0 goes to bits 31:24, offset 1 to 23:16, offset 2 to 15:8 and offset 3 to 7:0. The other lanes keep their values, and a byte store never raises the alignment error.
- R4: Op code 10 with address bit 0 clear writes din[15:0]. Offset 0 goes to bits 31:16 and offset 2 goes to bits 15:0, and the other half of the word is kept.
- R5: Op code 11 with address bits [1:0] equal to 00 replaces the whole word with din.
- R6: The alignment error is 1 in the same cycle for an enabled misaligned access: code 10 with address bit 0 set, or code 00 or 11 with address bits [1:0] not zero. Storage is then left unchanged and the read output is 0.
- R7: While the enable is low, nothing is written, the read output is 0 and the alignment error is 0.
- R8: During any enabled, aligned access, the read output shows the addressed word as it stood before the clock edge, including in a store cycle. A store takes effect on the rising edge.
- R9: Address bits above IDX_W+1 are ignored, so two addresses that differ only there refer to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores happen on the rising edge |
| rstN | input | 1 | Active-low asynchronous reset; clears storage |
| memEn | input | 1 | Access enable |
| memOp | input | 2 | 00 word read, 01 byte store, 10 halfword store, 11 word store |
| memAddr | input | 32 | Byte address |
| memDin | input | 32 | Store data |
| memDout | output | 32 | Addressed word, or 0 when disabled or misaligned |
| alignErr | output | 1 | Misaligned halfword or word access in this cycle |

## Verification
A wrong lane enable stays hidden at first. It only shows when the word is read back, where a neighbouring byte turns out corrupted, or a byte lands in the lane reflected about the word's centre. The bench therefore writes every offset and then reads each word in full. A flaw in the alignment decode shows as a wrong error flag in the same cycle. A store that slipped through despite the error shows on the next read of that word. An index that takes the wrong bits shows as aliasing between addresses that ought to differ, or the lack of it between addresses that ought to match.

// File: rtl/lane_mem_pkg.sv
package lane_mem_pkg;

  typedef enum logic [1:0] {
    OP_RD_WORD = 2'b00,
    OP_WR_BYTE = 2'b01,
    OP_WR_HALF = 2'b10,
    OP_WR_WORD = 2'b11
  } memOp_e;

  typedef enum logic [1:0] {
    FILL_BYTE = 2'd0,
    FILL_HALF = 2'd1,
    FILL_WORD = 2'd2
  } fillSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       rdEn;     // drive the addressed word on the read output
    logic [3:0] laneWe;   // bit 3 = bits 31:24 (byte offset 0)
    fillSel_e   fillSel;  // how store data is replicated across lanes
    logic       alignErr; // misaligned access this cycle
  } memStrobe_t;

endpackage

// File: rtl/lane_mem_ctl.sv
module lane_mem_ctl
  import lane_mem_pkg::*;
(
  input  logic       enable,
  input  logic [1:0] opCode,
  input  logic [1:0] byteOff,
  output memStrobe_t strobe
);

  logic misaligned;

  always_comb begin
    unique case (memOp_e'(opCode))
      OP_WR_BYTE: misaligned = 1'b0;
      OP_WR_HALF: misaligned = byteOff[0];
      default:    misaligned = |byteOff;
    endcase
  end

  always_comb begin
    strobe          = '0;
    strobe.fillSel  = FILL_WORD;
    if (enable) begin
      strobe.alignErr = misaligned;
      strobe.rdEn     = ~misaligned;
      if (!misaligned) begin
        unique case (memOp_e'(opCode))
          OP_WR_BYTE: begin
            strobe.laneWe  = 4'b1000 >> byteOff;
            strobe.fillSel = FILL_BYTE;
          end
          OP_WR_HALF: begin
            strobe.laneWe  = byteOff[1] ? 4'b0011 : 4'b1100;
            strobe.fillSel = FILL_HALF;
          end
          OP_WR_WORD: begin
            strobe.laneWe  = 4'b1111;
            strobe.fillSel = FILL_WORD;
          end
          default: strobe.laneWe = 4'b0000;
        endcase
      end
    end
  end

endmodule

// File: rtl/lane_mem_dp.sv
module lane_mem_dp
  import lane_mem_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic [31:0]      wrData,
  input  memStrobe_t       strobe,
  output logic [31:0]      rdData
);

  localparam int LANES = 4;

  logic [31:0] fillData;
  logic [31:0] rdWord;

  always_comb begin
    unique case (strobe.fillSel)
      FILL_BYTE: fillData = {LANES{wrData[7:0]}};
      FILL_HALF: fillData = {2{wrData[15:0]}};
      default:   fillData = wrData;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [7:0] laneMem [DEPTH];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) laneMem[i] <= '0;
      end else if (strobe.laneWe[g]) begin
        laneMem[wordIdx] <= fillData[8*g +: 8];
      end
    end

    assign rdWord[8*g +: 8] = laneMem[wordIdx];
  end

  assign rdData = strobe.rdEn ? rdWord : 32'd0;

endmodule

// File: rtl/lane_mem.sv
module lane_mem
  import lane_mem_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        memEn,
  input  logic [1:0]  memOp,
  input  logic [31:0] memAddr,
  input  logic [31:0] memDin,
  output logic [31:0] memDout,
  output logic        alignErr
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  memStrobe_t strobe;

  lane_mem_ctl ctlI (
    .enable (memEn),
    .opCode (memOp),
    .byteOff(memAddr[1:0]),
    .strobe (strobe)
  );

  lane_mem_dp #(.DEPTH(DEPTH), .IDX_W(IDX_W)) dpI (
    .clk    (clk),
    .rstN   (rstN),
    .wordIdx(memAddr[IDX_W+1:2]),
    .wrData (memDin),
    .strobe (strobe),
    .rdData (memDout)
  );

  assign alignErr = strobe.alignErr;

endmodule

// File: rtl/lane_mem_chk.sv
module lane_mem_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memEn,
  input logic [1:0]  memOp,
  input logic [31:0] memAddr,
  input logic [31:0] memDin,
  input logic [31:0] memDout,
  input logic        alignErr
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !memEn |-> (memDout == 32'd0 && !alignErr)); // R7

  AST_HALF_ODD_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memOp == 2'b10 && memAddr[0]) |-> (alignErr && memDout == 32'd0)); // R6

  AST_BYTE_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memOp == 2'b01) |-> !alignErr); // R3

  AST_WORD_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(memEn && memOp == 2'b11 && memAddr[1:0] == 2'b00)
     && memEn && memOp == 2'b00 && memAddr == $past(memAddr))
    |-> memDout == $past(memDin)); // R5

  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(memEn && memOp == 2'b00)
     && memEn && memOp == 2'b00 && $stable(memAddr))
    |-> $stable(memDout)); // R2

endmodule

bind lane_mem lane_mem_chk chkI (
  .clk     (clk),
  .rstN    (rstN),
  .memEn   (memEn),
  .memOp   (memOp),
  .memAddr (memAddr),
  .memDin  (memDin),
  .memDout (memDout),
  .alignErr(alignErr)
);

// File: tb/lane_mem_test.sv
`timescale 1ns/1ps
module lane_mem_test;

  localparam int DEPTH = 64;
  localparam int IDX_W = $clog2(DEPTH);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memEn = 1'b0;
  logic [1:0]  memOp = 2'b00;
  logic [31:0] memAddr = '0;
  logic [31:0] memDin = '0;
  logic [31:0] memDout;
  logic        alignErr;

  always #2 clk = ~clk; // 250 MHz

  lane_mem #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .memEn(memEn), .memOp(memOp),
    .memAddr(memAddr), .memDin(memDin), .memDout(memDout), .alignErr(alignErr)
  );

  typedef struct {
    logic [31:0] expDout;
    logic        expErr;
    string       tag;
  } expItem_t;

  expItem_t    sbQ[$];
  logic [31:0] model [DEPTH];
  int          checkCnt = 0;
  int          failCnt = 0;
  bit          done = 0;

  // Driver: applies one access and pushes what the ports must show
  task automatic access(input logic en, input logic [1:0] op,
                        input logic [31:0] addr, input logic [31:0] din,
                        input string tag);
    expItem_t    it;
    int          idx;
    logic        mis;
    logic [31:0] w;
    @(posedge clk); #1;
    memEn = en; memOp = op; memAddr = addr; memDin = din;
    idx = int'(addr[IDX_W+1:2]);
    mis = (op == 2'b01) ? 1'b0 : (op == 2'b10) ? addr[0] : (addr[1:0] != 2'b00);
    it.expErr  = en && mis;
    it.expDout = (en && !mis) ? model[idx] : 32'd0;
    it.tag     = tag;
    sbQ.push_back(it);
    if (en && !mis) begin
      w = model[idx];
      case (op)
        2'b01: w[31 - 8*addr[1:0] -: 8] = din[7:0];
        2'b10: w[31 - 8*addr[1:0] -: 16] = din[15:0];
        2'b11: w = din;
        default: ;
      endcase
      model[idx] = w;
    end
  endtask

  // Monitor: compares at the falling edge, away from the store edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbQ.size() > 0) begin
        expItem_t it;
        it = sbQ.pop_front();
        checkCnt++;
        if (memDout !== it.expDout || alignErr !== it.expErr) begin
          failCnt++;
          $display("FAIL %s: dout=%h err=%b expected dout=%h err=%b",
                   it.tag, memDout, alignErr, it.expDout, it.expErr);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    access(1, 2'b00, 32'h0000_0000, 0, "R1 reset word 0");
    access(1, 2'b00, 32'h0000_00FC, 0, "R1 reset last word");
    // R7: disabled outputs zero, disabled store ignored
    access(0, 2'b11, 32'h0000_0010, 32'hDEAD_BEEF, "R7 disabled store");
    access(1, 2'b00, 32'h0000_0010, 0, "R7 word untouched");
    // R5: word store and readback
    access(1, 2'b11, 32'h0000_0008, 32'h1234_5678, "R5 word store");
    access(1, 2'b00, 32'h0000_0008, 0, "R5 word readback");
    access(1, 2'b00, 32'h0000_0008, 0, "R2 repeated read");
    // R3: byte stores at every offset, big-endian lanes
    access(1, 2'b01, 32'h0000_000C, 32'hFFFF_FFA1, "R3 byte off0");
    access(1, 2'b00, 32'h0000_000C, 0, "R3 off0 lane 31:24");
    access(1, 2'b01, 32'h0000_000D, 32'h0000_00B2, "R3 byte off1");
    access(1, 2'b01, 32'h0000_000E, 32'h0000_00C3, "R3 byte off2");
    access(1, 2'b01, 32'h0000_000F, 32'h0000_00D4, "R3 byte off3");
    access(1, 2'b00, 32'h0000_000C, 0, "R3 all lanes");
    access(1, 2'b01, 32'h0000_000A, 32'h0000_0099, "R3 byte into word");
    access(1, 2'b00, 32'h0000_0008, 0, "R3 neighbours kept");
    // R4: halfword stores
    access(1, 2'b10, 32'h0000_0014, 32'hAAAA_CAFE, "R4 half off0");
    access(1, 2'b00, 32'h0000_0014, 0, "R4 upper half");
    access(1, 2'b10, 32'h0000_0016, 32'h5555_F00D, "R4 half off2");
    access(1, 2'b00, 32'h0000_0014, 0, "R4 both halves");
    // R6: misaligned accesses
    access(1, 2'b10, 32'h0000_0015, 32'h0000_1111, "R6 half odd");
    access(1, 2'b11, 32'h0000_0016, 32'h2222_2222, "R6 word off2");
    access(1, 2'b11, 32'h0000_0009, 32'h3333_3333, "R6 word off1");
    access(1, 2'b00, 32'h0000_0017, 0, "R6 read off3");
    access(1, 2'b00, 32'h0000_0014, 0, "R6 word unchanged");
    access(1, 2'b00, 32'h0000_0008, 0, "R6 word8 unchanged");
    // R8: output during a store shows prior contents
    access(1, 2'b11, 32'h0000_0020, 32'h0BAD_F00D, "R8 store shows old");
    access(1, 2'b11, 32'h0000_0020, 32'h7777_0000, "R8 second store shows first");
    access(1, 2'b00, 32'h0000_0020, 0, "R8 final value");
    // R9: upper address bits ignored
    access(1, 2'b11, 32'h8000_0104, 32'hFACE_0042, "R9 aliased store");
    access(1, 2'b00, 32'h0000_0004, 0, "R9 alias read low");
    access(1, 2'b00, 32'h0F00_0204, 0, "R9 alias read high");
    access(0, 2'b00, 32'h0000_0004, 0, "R7 read disabled");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule